// File: doc/BRIEF.md
# Multi-Core Boot Release Table

This block is a memory-mapped table of per-core boot slots. Secondary processor cores stay parked until software fills in their slot and clears the hold bit. Each slot is 32 bytes. A slot holds a 64-bit jump target, a 64-bit argument, a 32-bit processor-ID word and padding words. Software reaches the table through a simple slave port. The port supports 1-, 2- and 4-byte accesses, and multi-byte values are big-endian.

After every accepted write, the block re-examines the written slot. If the hold bit is clear, the owning core gets a one-cycle release strobe. At the same time, that core's output bundle is loaded with three values:

- the in-window start offset,
- the base of its translation window,
- the argument value for its first argument register.

The translation window is 2^WIN_BITS bytes, which is 64 MiB by default. The first slot belongs to the primary core and is never acted on. Slots of cores that are not fitted are also never acted on.

Top module: `bootReleaseTable`

## Requirements
- R1: After reset, each slot k holds the value 1 in its 64-bit target field (byte offsets 0..7), k in its argument field (offsets 8..15) and k in its 32-bit ID field (offsets 20..23). All other bytes are 0, and no release strobe is active.
- R2: `busSize` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The byte at the lowest address is the most significant byte of a 2- or 4-byte value. Read data is right-aligned in `busRdata`.
- R3: Every request cycle is answered on the next clock edge with `busRvalid`. For a legal read, `busRdata` carries the data in that same cycle.
- R4: `busSize` = 3 raises `busErr` together with `busRvalid`. Such a write stores nothing and causes no release. Such a read returns 0.
- R5: Writes to slot 0 are discarded, and core 0 is never released.
- R6: Writes to a slot whose index is NUM_PRESENT or higher are discarded.
- R7: A write that is accepted into a slot and leaves bit 0 of that slot's target field clear (bit 0 of byte offset 7) releases the core with the slot's index. `coreRelease[k]` is high for one cycle, on the second clock edge after the write is sampled. The strobe repeats for every such write. An accepted write that leaves bit 0 set gives no strobe.
- R8: On release of core k, the bundle is loaded and then held until the next release of k:
  - `coreStartOff[k]` takes target[WIN_BITS-1:0];
  - `coreWinBase[k]` takes the target with its low WIN_BITS bits cleared;
  - `coreArg[k]` takes the argument field.
- R9: On release of core k, the slot's ID field is rewritten to k. This rewrite wins over a bus write to the same bytes at the same edge.
- R10: At most one `coreRelease` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits [ADDR_W-1:5] select the slot |
| busSize | input | 2 | Access width code |
| busWdata | input | 32 | Right-aligned write data |
| busRdata | output | 32 | Right-aligned read data |
| busRvalid | output | 1 | Response strobe |
| busErr | output | 1 | Illegal-size flag, valid with busRvalid |
| coreRelease | output | NUM_SLOTS | Per-core one-cycle release strobe |
| coreStartOff | output | NUM_SLOTS x WIN_BITS | Per-core start offset within the window |
| coreWinBase | output | NUM_SLOTS x 64 | Per-core translation window base |
| coreArg | output | NUM_SLOTS x 64 | Per-core initial argument value |

## Verification
The bench builds the table with NUM_SLOTS = 8 and NUM_PRESENT = 5, with WIN_BITS left at 26. This leaves slots 5 to 7 unfitted, so discarded writes to an absent core can be checked. Slot 4 sits at the edge of the fitted range and is checked as a live release. The 64 MiB window keeps the target split realistic, so the bench uses a target with bits both above and below bit 26.

// File: rtl/spinTablePkg.sv
package spinTablePkg;

  // access width codes on the slave port
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  localparam int SLOT_BYTES = 32;
  localparam int SLOT_BITS  = SLOT_BYTES * 8;
  localparam int OFF_BITS   = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCommit;   // store this cycle's write
    logic rdLoad;     // capture this cycle's read
    logic chkEn;      // evaluate hold bit of chkIdx slot
  } ctlStrobes_t;

endpackage

// File: rtl/spinTableCtl.sv
module spinTableCtl
  import spinTablePkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int NUM_PRESENT = 32,
  localparam int IDX_W  = $clog2(NUM_SLOTS),
  localparam int ADDR_W = IDX_W + OFF_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output logic              busRvalid,
  output logic              busErr,
  output ctlStrobes_t       strb,
  output logic [IDX_W-1:0]  chkIdx
);

  logic [IDX_W-1:0] reqIdx;
  logic             sizeOk;
  logic             slotLive;
  logic             wrCommit;
  logic             rspQ, errQ, chkQ;
  logic [IDX_W-1:0] chkIdxQ;

  assign reqIdx   = busAddr[ADDR_W-1:OFF_BITS];
  assign sizeOk   = (accSize_e'(busSize) != SZ_BAD);
  assign slotLive = (reqIdx != '0) && (32'(reqIdx) < 32'(NUM_PRESENT));
  assign wrCommit = busReq && busWrite && sizeOk && slotLive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspQ    <= 1'b0;
      errQ    <= 1'b0;
      chkQ    <= 1'b0;
      chkIdxQ <= '0;
    end else begin
      rspQ    <= busReq;
      errQ    <= busReq && !sizeOk;
      chkQ    <= wrCommit;
      chkIdxQ <= reqIdx;
    end
  end

  assign strb.wrCommit = wrCommit;
  assign strb.rdLoad   = busReq && !busWrite && sizeOk;
  assign strb.chkEn    = chkQ;
  assign chkIdx        = chkIdxQ;
  assign busRvalid     = rspQ;
  assign busErr        = errQ;

  // R3: one response per request, one edge later
  assert_rvalid_follows_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busRvalid);

  // R4: error flag only for an illegal size
  assert_err_needs_bad_size_R4: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busReq && busSize == 2'd3));

  // R4: an illegal write never reaches the release check
  assert_no_check_after_bad_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.chkEn |-> $past(busSize != 2'd3 && busWrite));

endmodule

// File: rtl/spinTableData.sv
module spinTableData
  import spinTablePkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int WIN_BITS    = 26,
  localparam int IDX_W  = $clog2(NUM_SLOTS),
  localparam int ADDR_W = IDX_W + OFF_BITS
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctlStrobes_t                        strb,
  input  logic [IDX_W-1:0]                   chkIdx,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [1:0]                         busSize,
  input  logic [31:0]                        busWdata,
  output logic [31:0]                        busRdata,
  output logic [NUM_SLOTS-1:0]               coreRelease,
  output logic [NUM_SLOTS-1:0][WIN_BITS-1:0] coreStartOff,
  output logic [NUM_SLOTS-1:0][63:0]         coreWinBase,
  output logic [NUM_SLOTS-1:0][63:0]         coreArg
);

  // slot layout, MSB first: target[255:192] arg[191:128] pad[127:96] id[95:64] pad[63:0]
  logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] tbl;

  logic [ADDR_W-1:0] laneAddr [4];
  logic              laneEn   [4];
  logic [7:0]        laneData [4];
  logic [7:0]        laneRd   [4];
  logic [2:0]        nBytes;
  logic [31:0]       rdAssembled;
  logic [31:0]       rdataQ;

  logic [63:0]       chkTarget;
  logic [63:0]       chkArg;
  logic              fire;

  always_comb begin
    case (accSize_e'(busSize))
      SZ_BYTE: nBytes = 3'd1;
      SZ_HALF: nBytes = 3'd2;
      SZ_WORD: nBytes = 3'd4;
      default: nBytes = 3'd0;
    endcase
    for (int k = 0; k < 4; k++) begin
      laneAddr[k] = busAddr + ADDR_W'(k);
      laneEn[k]   = (3'(k) < nBytes);
      laneData[k] = 8'(busWdata >> (8 * (32'(nBytes) - 1 - k)));
      laneRd[k]   = tbl[laneAddr[k][ADDR_W-1:OFF_BITS]][{~laneAddr[k][OFF_BITS-1:0], 3'b000} +: 8];
    end
    case (accSize_e'(busSize))
      SZ_BYTE: rdAssembled = {24'd0, laneRd[0]};
      SZ_HALF: rdAssembled = {16'd0, laneRd[0], laneRd[1]};
      SZ_WORD: rdAssembled = {laneRd[0], laneRd[1], laneRd[2], laneRd[3]};
      default: rdAssembled = '0;
    endcase
  end

  assign chkTarget = tbl[chkIdx][255:192];
  assign chkArg    = tbl[chkIdx][191:128];
  assign fire      = strb.chkEn && !chkTarget[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_SLOTS; e++) begin
        tbl[e] <= {64'd1, 64'(e), 32'd0, 32'(e), 64'd0};
      end
      rdataQ <= '0;
    end else begin
      rdataQ <= strb.rdLoad ? rdAssembled : 32'd0;
      if (strb.wrCommit) begin
        for (int k = 0; k < 4; k++) begin
          if (laneEn[k]) begin
            tbl[laneAddr[k][ADDR_W-1:OFF_BITS]][{~laneAddr[k][OFF_BITS-1:0], 3'b000} +: 8] <= laneData[k];
          end
        end
      end
      // released core reports its own ID; placed last so it wins
      if (fire) begin
        tbl[chkIdx][95:64] <= 32'(chkIdx);
      end
    end
  end

  assign busRdata = rdataQ;

  // per-core release bundle
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : genCore
    logic                relR;
    logic [WIN_BITS-1:0] startR;
    logic [63:0]         baseR;
    logic [63:0]         argR;
    logic                hit;

    assign hit = fire && (chkIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        relR   <= 1'b0;
        startR <= '0;
        baseR  <= '0;
        argR   <= '0;
      end else begin
        relR <= hit;
        if (hit) begin
          startR <= chkTarget[WIN_BITS-1:0];
          baseR  <= {chkTarget[63:WIN_BITS], WIN_BITS'(0)};
          argR   <= chkArg;
        end
      end
    end

    assign coreRelease[g]  = relR;
    assign coreStartOff[g] = startR;
    assign coreWinBase[g]  = baseR;
    assign coreArg[g]      = argR;
  end

  // R10: one core released at a time
  assert_release_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(coreRelease));

  // R5: the primary core is never released
  assert_no_primary_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    !coreRelease[0]);

  // R5: the primary slot contents never change
  assert_slot0_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    $stable(tbl[0]));

  // R7: a strobe needs a pending check one edge earlier
  assert_release_needs_check_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|coreRelease) |-> $past(strb.chkEn));

  // R9: after a release the slot's ID field holds its index
  assert_id_rewritten_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|coreRelease) |-> (tbl[$past(chkIdx)][95:64] == 32'($past(chkIdx))));

endmodule

// File: rtl/bootReleaseTable.sv
module bootReleaseTable
  import spinTablePkg::*;
#(
  parameter int NUM_SLOTS   = 32,
  parameter int NUM_PRESENT = 32,
  parameter int WIN_BITS    = 26,
  localparam int IDX_W  = $clog2(NUM_SLOTS),
  localparam int ADDR_W = IDX_W + OFF_BITS
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               busReq,
  input  logic                               busWrite,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [1:0]                         busSize,
  input  logic [31:0]                        busWdata,
  output logic [31:0]                        busRdata,
  output logic                               busRvalid,
  output logic                               busErr,
  output logic [NUM_SLOTS-1:0]               coreRelease,
  output logic [NUM_SLOTS-1:0][WIN_BITS-1:0] coreStartOff,
  output logic [NUM_SLOTS-1:0][63:0]         coreWinBase,
  output logic [NUM_SLOTS-1:0][63:0]         coreArg
);

  ctlStrobes_t      strb;
  logic [IDX_W-1:0] chkIdx;

  spinTableCtl #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_PRESENT(NUM_PRESENT)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busRvalid(busRvalid),
    .busErr   (busErr),
    .strb     (strb),
    .chkIdx   (chkIdx)
  );

  spinTableData #(
    .NUM_SLOTS(NUM_SLOTS),
    .WIN_BITS (WIN_BITS)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .chkIdx      (chkIdx),
    .busAddr     (busAddr),
    .busSize     (busSize),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .coreRelease (coreRelease),
    .coreStartOff(coreStartOff),
    .coreWinBase (coreWinBase),
    .coreArg     (coreArg)
  );

endmodule

// File: tb/tb_bootReleaseTable.sv
module tb_bootReleaseTable;

  localparam int NS = 8;
  localparam int NP = 5;
  localparam int WB = 26;
  localparam int AW = $clog2(NS) + 5;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   busReq = 1'b0;
  logic                   busWrite = 1'b0;
  logic [AW-1:0]          busAddr = '0;
  logic [1:0]             busSize = '0;
  logic [31:0]            busWdata = '0;
  logic [31:0]            busRdata;
  logic                   busRvalid;
  logic                   busErr;
  logic [NS-1:0]          coreRelease;
  logic [NS-1:0][WB-1:0]  coreStartOff;
  logic [NS-1:0][63:0]    coreWinBase;
  logic [NS-1:0][63:0]    coreArg;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  bootReleaseTable #(.NUM_SLOTS(NS), .NUM_PRESENT(NP), .WIN_BITS(WB)) dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .busErr(busErr),
    .coreRelease(coreRelease), .coreStartOff(coreStartOff),
    .coreWinBase(coreWinBase), .coreArg(coreArg)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d, output logic e);
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b1; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
    e = busErr;
  endtask

  task automatic busRd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d, output logic e);
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b0; busAddr = a; busSize = sz;
    @(negedge clk);
    busReq = 1'b0;
    check(busRvalid === 1'b1, "R3 rvalid", 64'(busRvalid), 64'd1);
    d = busRdata;
    e = busErr;
  endtask

  // write, then watch the release strobe for two cycles
  task automatic wrWatch(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d,
                         input logic [NS-1:0] expRel, input string tag);
    logic e;
    busWr(a, sz, d, e);
    @(negedge clk);
    check(coreRelease === expRel, {tag, " strobe"}, 64'(coreRelease), 64'(expRel));
    @(negedge clk);
    check(coreRelease === '0, {tag, " strobe width"}, 64'(coreRelease), 64'd0);
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    logic e;
    busRd(a, sz, d, e);
    check(d === exp && e === 1'b0, tag, 64'(d), 64'(exp));
  endtask

  task automatic testReset();
    check(coreRelease === '0, "R1 no strobe at reset", 64'(coreRelease), 64'd0);
    rdCheck(8'h60, 2'd2, 32'h0, "R1 target hi");
    rdCheck(8'h64, 2'd2, 32'h1, "R1 target lo");
    rdCheck(8'h68, 2'd2, 32'h0, "R1 arg hi");
    rdCheck(8'h6C, 2'd2, 32'h3, "R1 arg lo");
    rdCheck(8'h74, 2'd2, 32'h3, "R1 id");
    rdCheck(8'h0C, 2'd2, 32'h0, "R1 slot0 arg");
  endtask

  task automatic testEndian();
    wrWatch(8'h50, 2'd2, 32'hA1B2C3D4, '0, "R2 word write");
    rdCheck(8'h50, 2'd0, 32'hA1, "R2 byte0");
    rdCheck(8'h51, 2'd0, 32'hB2, "R2 byte1");
    rdCheck(8'h53, 2'd0, 32'hD4, "R2 byte3");
    rdCheck(8'h52, 2'd1, 32'hC3D4, "R2 half read");
    wrWatch(8'h51, 2'd0, 32'h55, '0, "R2 byte write");
    rdCheck(8'h50, 2'd2, 32'hA155C3D4, "R2 after byte");
    wrWatch(8'h50, 2'd1, 32'h1234, '0, "R2 half write");
    rdCheck(8'h50, 2'd2, 32'h1234C3D4, "R2 after half");
  endtask

  task automatic testRelease();
    wrWatch(8'h74, 2'd2, 32'hDEADBEEF, '0, "R7 held id write");
    rdCheck(8'h74, 2'd2, 32'hDEADBEEF, "R9 id before release");
    wrWatch(8'h6C, 2'd2, 32'hCAFE0001, '0, "R7 held arg write");
    wrWatch(8'h60, 2'd2, 32'h00000012, '0, "R7 held target hi");
    wrWatch(8'h64, 2'd2, 32'h0ABCDEF0, 8'b0000_1000, "R7 release core3");
    check(coreStartOff[3] === 26'h2BCDEF0, "R8 start offset", 64'(coreStartOff[3]), 64'h2BCDEF0);
    check(coreWinBase[3] === 64'h0000001208000000, "R8 window base", coreWinBase[3], 64'h0000001208000000);
    check(coreArg[3] === 64'h00000000CAFE0001, "R8 argument", coreArg[3], 64'h00000000CAFE0001);
    rdCheck(8'h74, 2'd2, 32'h3, "R9 id after release");
    wrWatch(8'h6C, 2'd2, 32'h77, 8'b0000_1000, "R7 repeated release");
    check(coreArg[3] === 64'h77, "R8 argument update", coreArg[3], 64'h77);
    wrWatch(8'h67, 2'd0, 32'h01, '0, "R7 hold bit set again");
    check(coreArg[3] === 64'h77, "R8 bundle held", coreArg[3], 64'h77);
    check(coreStartOff[3] === 26'h2BCDEF0, "R8 offset held", 64'(coreStartOff[3]), 64'h2BCDEF0);
  endtask

  task automatic testDiscard();
    wrWatch(8'h04, 2'd2, 32'h0, '0, "R5 primary write");
    rdCheck(8'h04, 2'd2, 32'h1, "R5 primary unchanged");
    wrWatch(8'hC4, 2'd2, 32'h0, '0, "R6 absent write");
    rdCheck(8'hC4, 2'd2, 32'h1, "R6 absent unchanged");
    wrWatch(8'h84, 2'd2, 32'h100, 8'b0001_0000, "R6 last present core");
    check(coreStartOff[4] === 26'h100, "R8 core4 offset", 64'(coreStartOff[4]), 64'h100);
    check(coreWinBase[4] === 64'h0, "R8 core4 base", coreWinBase[4], 64'h0);
    check(coreArg[4] === 64'h4, "R8 core4 arg", coreArg[4], 64'h4);
    check(coreArg[3] === 64'h77, "R10 other core untouched", coreArg[3], 64'h77);
  endtask

  task automatic testBadSize();
    logic [31:0] d;
    logic e;
    busRd(8'h64, 2'd3, d, e);
    check(e === 1'b1, "R4 read err", 64'(e), 64'd1);
    check(d === 32'h0, "R4 read data", 64'(d), 64'd0);
    busWr(8'h24, 2'd3, 32'h0, e);
    check(e === 1'b1, "R4 write err", 64'(e), 64'd1);
    @(negedge clk);
    check(coreRelease === '0, "R4 no release", 64'(coreRelease), 64'd0);
    rdCheck(8'h24, 2'd2, 32'h1, "R4 write not stored");
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEndian();
    testRelease();
    testDiscard();
    testBadSize();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule